// File: doc/BRIEF.md
# Two-Bank Data Memory Address Decoder

This block sits between the operand path of a small 8-bit processor core and its data memory. Each access presents either a direct 7-bit operand address, which is joined with a one-bit bank select from the core's status register, or the reserved operand address 00h. The reserved address makes the access indirect: the full 8-bit pointer register then supplies both bank and offset. The decoded address lands in one of three regions. The low 32 offsets of either bank go to an external peripheral register port. A 64-byte general-purpose RAM, held inside the block, appears at offsets 20h to 5Fh of both banks. Every other offset is unimplemented.

Writes to the RAM take effect at the clock edge. Peripheral register strobes, offset and bank are driven combinationally in the cycle of the access, so the register that owns the location can act in that cycle. Read data is registered: it appears on the clock edge that ends the read cycle and is held until the next read. Unimplemented locations and the indirect port itself read as zero and absorb writes.

Top module: `regfile_bank_decoder`

## Requirements
- R1: A direct access (operand field not 00h) decodes the address {bank_sel, dir_addr}. bank_sel = 0 selects bank 0 and bank_sel = 1 selects bank 1.
- R2: A decoded offset from 01h to 1Fh raises sfr_sel. sfr_offset then carries the offset's low 5 bits and sfr_bank carries the bank bit. sfr_re equals rd_en and sfr_we equals wr_en during that access. A read returns sfr_rdata, and sfr_sel and gpr_hit are never high together.
- R3: Offsets 20h to 5Fh raise gpr_hit and reach RAM cell (offset - 20h) in either bank. A byte written through bank 0 reads back through bank 1 at the same offset.
- R4: Offsets 60h to 7Fh are unimplemented. They read as 00h, raise neither sfr_sel nor gpr_hit, and a write to them changes no RAM cell.
- R5: An operand field of 00h makes the access indirect. The address is the whole fsr value, with bit 7 as the bank and bits 6:0 as the offset, and bank_sel has no effect.
- R6: An indirect access with fsr bits 6:0 equal to zero (fsr = 00h or 80h) reads as 00h, raises no strobe and changes no RAM cell.
- R7: rd_data takes the read value on the rising edge that ends a cycle with rd_en high, and holds its value through cycles with rd_en low.
- R8: After reset rd_data is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read access this cycle |
| wr_en | input | 1 | Write access this cycle |
| dir_addr | input | 7 | Operand address field (00h selects indirect) |
| bank_sel | input | 1 | Bank select bit from the status register |
| fsr | input | 8 | Pointer register used by indirect accesses |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| sfr_sel | output | 1 | Access targets a peripheral register |
| sfr_bank | output | 1 | Bank of the peripheral register access |
| sfr_offset | output | 5 | Peripheral register offset |
| sfr_re | output | 1 | Peripheral register read strobe |
| sfr_we | output | 1 | Peripheral register write strobe |
| sfr_wdata | output | 8 | Data for the peripheral register write |
| sfr_rdata | input | 8 | Data from the addressed peripheral register |
| gpr_hit | output | 1 | Access targets general-purpose RAM |

## Verification
The decode outputs (sfr_sel, sfr_bank, sfr_offset, the two strobes and gpr_hit) are combinational, so the bench samples them in the same cycle the access is driven, just before the rising edge. Read data passes through one register, so rd_data is compared 1 ns after the edge that ends the read cycle, against a behavioural model that keeps its own copy of RAM contents. RAM writes commit at that same edge, and their effect is observed only through later reads.

// File: rtl/rfd_pkg.sv
package rfd_pkg;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_SFR  = 2'd1,
        REG_GPR  = 2'd2
    } region_e;

endpackage

// File: rtl/rfd_addr_decode.sv
module rfd_addr_decode
    import rfd_pkg::*;
#(
    parameter int OFF_W     = 7,
    parameter int SFR_COUNT = 32,
    parameter int GPR_DEPTH = 64,
    localparam int IDX_W    = $clog2(GPR_DEPTH)
) (
    input  logic [OFF_W-1:0] dir_addr,
    input  logic             bank_sel,
    input  logic [OFF_W:0]   fsr,
    output region_e          region,
    output logic             bank,
    output logic [OFF_W-1:0] offset,
    output logic [IDX_W-1:0] gpr_idx
);
    localparam int GPR_BASE = SFR_COUNT;
    localparam int GPR_END  = SFR_COUNT + GPR_DEPTH;

    logic           indirect;
    logic [OFF_W:0] eff_addr;

    always_comb begin
        indirect = (dir_addr == '0);
        eff_addr = indirect ? fsr : {bank_sel, dir_addr};
        bank     = eff_addr[OFF_W];
        offset   = eff_addr[OFF_W-1:0];
        gpr_idx  = IDX_W'(offset - OFF_W'(GPR_BASE));
        if (offset == '0)
            region = REG_NONE;
        else if (int'(offset) < GPR_BASE)
            region = REG_SFR;
        else if (int'(offset) < GPR_END)
            region = REG_GPR;
        else
            region = REG_NONE;
    end

endmodule

// File: rtl/rfd_gpr_ram.sv
module rfd_gpr_ram #(
    parameter int DW       = 8,
    parameter int DEPTH    = 64,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

    // R3: a write lands in the addressed cell
    p_ram_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(idx)] == $past(wdata));

endmodule

// File: rtl/regfile_bank_decoder.sv
module regfile_bank_decoder
    import rfd_pkg::*;
#(
    parameter int DW        = 8,
    parameter int OFF_W     = 7,
    parameter int SFR_COUNT = 32,
    parameter int GPR_DEPTH = 64,
    localparam int SFR_W    = $clog2(SFR_COUNT),
    localparam int IDX_W    = $clog2(GPR_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] dir_addr,
    input  logic             bank_sel,
    input  logic [OFF_W:0]   fsr,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data,
    output logic             sfr_sel,
    output logic             sfr_bank,
    output logic [SFR_W-1:0] sfr_offset,
    output logic             sfr_re,
    output logic             sfr_we,
    output logic [DW-1:0]    sfr_wdata,
    input  logic [DW-1:0]    sfr_rdata,
    output logic             gpr_hit
);
    typedef struct packed {
        logic [DW-1:0] rd_data;
    } state_t;

    state_t state_d, state_q;

    region_e          region;
    logic             bank;
    logic [OFF_W-1:0] offset;
    logic [IDX_W-1:0] gpr_idx;
    logic [DW-1:0]    gpr_rdata;
    logic             gpr_we;

    rfd_addr_decode #(
        .OFF_W    (OFF_W),
        .SFR_COUNT(SFR_COUNT),
        .GPR_DEPTH(GPR_DEPTH)
    ) u_decode (
        .dir_addr(dir_addr),
        .bank_sel(bank_sel),
        .fsr     (fsr),
        .region  (region),
        .bank    (bank),
        .offset  (offset),
        .gpr_idx (gpr_idx)
    );

    rfd_gpr_ram #(
        .DW   (DW),
        .DEPTH(GPR_DEPTH)
    ) u_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (gpr_we),
        .idx  (gpr_idx),
        .wdata(wr_data),
        .rdata(gpr_rdata)
    );

    always_comb begin
        sfr_sel    = (region == REG_SFR);
        gpr_hit    = (region == REG_GPR);
        sfr_bank   = bank;
        sfr_offset = SFR_W'(offset);
        sfr_re     = sfr_sel && rd_en;
        sfr_we     = sfr_sel && wr_en;
        sfr_wdata  = wr_data;
        gpr_we     = gpr_hit && wr_en;

        state_d = state_q;
        if (rd_en) begin
            case (region)
                REG_SFR: state_d.rd_data = sfr_rdata;
                REG_GPR: state_d.rd_data = gpr_rdata;
                default: state_d.rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rd_data = state_q.rd_data;

    // R2: peripheral and RAM regions are exclusive
    p_excl_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sfr_sel, gpr_hit}));

    // R2: peripheral read data reaches rd_data one edge later
    p_sfr_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sfr_sel) |=> rd_data == $past(sfr_rdata));

    // R4: reads outside both regions return zero
    p_unimpl_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !sfr_sel && !gpr_hit) |=> rd_data == '0);

    // R6: indirect port pointing at itself strobes nothing
    p_virtual_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_addr == '0 && fsr[OFF_W-1:0] == '0) |-> (!sfr_re && !sfr_we && !gpr_hit));

    // R7: rd_data holds without a read
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/sim_regfile_bank_decoder.sv
module sim_regfile_bank_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [6:0] dir_addr = '0;
    logic       bank_sel = 1'b0;
    logic [7:0] fsr = '0, wr_data = '0, sfr_rdata = '0;
    logic [7:0] rd_data, sfr_wdata;
    logic       sfr_sel, sfr_bank, sfr_re, sfr_we, gpr_hit;
    logic [4:0] sfr_offset;

    int checks = 0;
    int fails  = 0;
    int ref_ram [64];
    int ref_rd = 0;

    always #4 clk = ~clk;

    regfile_bank_decoder u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .dir_addr(dir_addr), .bank_sel(bank_sel), .fsr(fsr),
        .wr_data(wr_data), .rd_data(rd_data), .sfr_sel(sfr_sel),
        .sfr_bank(sfr_bank), .sfr_offset(sfr_offset), .sfr_re(sfr_re),
        .sfr_we(sfr_we), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .gpr_hit(gpr_hit)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One access: drive at negedge, check decode before the edge, rd_data after it.
    task automatic access(string req, bit rd, bit wr, int dir, bit bs, int f, int wd, int srd);
        int eff, off, bnk, region, idx, rdv;
        @(negedge clk);
        rd_en = rd; wr_en = wr; dir_addr = 7'(dir); bank_sel = bs;
        fsr = 8'(f); wr_data = 8'(wd); sfr_rdata = 8'(srd);
        eff = (dir == 0) ? f : (int'(bs) * 128 + dir);
        bnk = eff / 128;
        off = eff % 128;
        region = (off == 0) ? 0 : (off < 32) ? 1 : (off < 96) ? 2 : 0;
        idx = off - 32;
        #3;
        check(req, "sfr_sel", int'(sfr_sel), int'(region == 1));
        check(req, "gpr_hit", int'(gpr_hit), int'(region == 2));
        check(req, "sfr_re", int'(sfr_re), int'(region == 1 && rd));
        check(req, "sfr_we", int'(sfr_we), int'(region == 1 && wr));
        if (region == 1) begin
            check(req, "sfr_offset", int'(sfr_offset), off % 32);
            check(req, "sfr_bank", int'(sfr_bank), bnk);
        end
        if (rd) begin
            rdv = (region == 1) ? srd : (region == 2) ? ref_ram[idx] : 0;
            ref_rd = rdv;
        end
        @(posedge clk);
        if (wr && region == 2) ref_ram[idx] = wd;
        #1;
        check(req, "rd_data", int'(rd_data), ref_rd);
    endtask

    initial begin : watchdog
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #20;
        check("R8", "reset rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        // R3/R1: fill RAM through bank 0, read back through bank 1
        for (int i = 0; i < 64; i++) access("R3", 0, 1, 32 + i, 0, 0, (i * 37 + 5) % 256, 0);
        for (int i = 0; i < 64; i++) access("R3", 1, 0, 32 + i, 1, 0, 0, 8'hEE);
        // R2: peripheral registers in both banks
        access("R2", 1, 0, 5, 0, 0, 0, 8'h5A);
        access("R2", 0, 1, 6, 1, 0, 8'h33, 8'h11);
        access("R1", 1, 0, 31, 1, 0, 0, 8'hC3);
        access("R1", 1, 0, 1, 0, 0, 0, 8'h7E);
        // R4: unimplemented range absorbs writes and reads zero
        access("R4", 0, 1, 8'h60, 0, 0, 8'hFF, 0);
        access("R4", 0, 1, 8'h7F, 1, 0, 8'hFF, 0);
        access("R4", 1, 0, 8'h60, 0, 0, 0, 8'hAA);
        access("R4", 1, 0, 8'h7F, 1, 0, 0, 8'hAA);
        access("R3", 1, 0, 32 + 63, 0, 0, 0, 0);
        // R5: indirect uses full fsr, bank_sel ignored
        access("R5", 1, 0, 0, 0, 8'hA5, 0, 0);
        access("R5", 0, 1, 0, 0, 8'hC0, 8'h9D, 0);
        access("R5", 1, 0, 0, 1, 8'h40, 0, 0);
        access("R5", 1, 0, 0, 1, 8'h03, 0, 8'h21);
        access("R5", 1, 0, 0, 0, 8'h83, 0, 8'h22);
        access("R5", 1, 0, 0, 1, 8'hE0, 0, 8'h44);
        // R6: indirect port pointing at itself
        access("R6", 1, 0, 0, 0, 8'h00, 0, 8'h99);
        access("R6", 0, 1, 0, 1, 8'h80, 8'h77, 8'h99);
        access("R6", 1, 0, 0, 1, 8'h80, 0, 8'h99);
        // R7: rd_data holds while no read occurs
        access("R2", 1, 0, 9, 0, 0, 0, 8'h6B);
        access("R7", 0, 0, 9, 0, 0, 0, 8'h01);
        access("R7", 0, 1, 32, 0, 0, 8'h12, 8'h02);
        access("R7", 1, 0, 32, 1, 0, 0, 0);
        // mixed pattern sweep
        for (int i = 0; i < 200; i++) begin
            int a = (i * 53 + 11) % 128;
            int f = (i * 29 + 7) % 256;
            access("R1", (i % 3) != 0, (i % 3) == 0, a, (i % 2) == 1, f, (i * 13) % 256, (i * 71) % 256);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule